// File: doc/BRIEF.md
# Two-Stage Bit Rate Generator

This block turns a fast input clock into the two timing strobes a serial transmitter or receiver needs. An optional divide-by-8 prescaler feeds a 16-bit clock divider. The clock divider produces a one-clock sample strobe. A second, 8-bit counter groups a programmable number of those samples into one bit period and raises a bit tick on the last sample of each bit. The resulting bit rate is the selected clock divided by the clock divisor times (bit divisor + 1).

Software computes the divisors and writes them in one cycle through a plain write strobe. The block holds each write in a pending copy. It moves that copy into the running counters only when the clock divider wraps, so a period already in progress always completes at its old length. While the clock divisor is zero the generator is stopped and accepts a new setting on the very next cycle. There is no data stream through this block, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `bitrate_gen`

## Requirements
- R1: A synchronous reset clears the prescaler, the clock-divider count and the sample count. It drives both outputs low and leaves the running setting at clock divisor 0 (stopped), so no strobe appears after reset until a setting is written.
- R2: With `cfg_pre_sel` = 0 and a running clock divisor C ≥ 1, `sample_stb` is a one-clock pulse that repeats every C clocks. For C = 1 it is high on every clock.
- R3: With `cfg_pre_sel` = 1 the input clock is first divided by 8, so `sample_stb` repeats every 8·C clocks.
- R4: `bit_tick` is asserted only in a cycle where `sample_stb` is asserted. Counting the first strobe after a setting is started from a stopped state as number 1, strobe n carries a tick exactly when n is a multiple of B+1, where B is the effective bit divisor.
- R5: A written bit divisor below 4 is used as 4. Values from 4 to 255 are used as written.
- R6: A clock divisor of 0 stops the generator: neither `sample_stb` nor `bit_tick` is asserted.
- R7: When the generator is stopped, a write takes effect in the next cycle. With P = 8 if the prescaler is selected, else 1, the first `sample_stb` is high in the cycle after the (P·C+1)-th rising clock edge after the write edge.
- R8: When the generator is running, a write takes effect at the first clock-divider wrap after the write edge. The period in progress keeps its old length, and the following periods use the new divisor, bit divisor and prescale selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe for the three setting inputs |
| cfg_clk_div | input | CD_W (16) | Clock divisor; 0 stops the generator |
| cfg_bit_div | input | BD_W (8) | Bit divisor; samples per bit minus one, minimum 4 |
| cfg_pre_sel | input | 1 | 1 selects the divide-by-8 prescaler, 0 bypasses it |
| sample_stb | output | 1 | One-clock sample strobe at the divided rate |
| bit_tick | output | 1 | One-clock bit tick on the last sample of each bit |

## Verification
The hardest situation to reach is a write that arrives while the counters are running: the new setting must wait in its pending copy and be applied at the wrap, neither early (which would shorten a period) nor one period late. The bench gets there by watching for a strobe and issuing the write right after it, so the write edge falls at a known count inside the period. It then measures the gap that completes the old period and the gap after it. The same method covers a switch of the prescaler from bypass to divide-by-8 in mid-run. That switch also checks that the prescaler restarts at the wrap and does not cut the first long period short.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;

  // Prescale selection, one bit of the setting
  typedef enum logic {
    PRE_BYPASS = 1'b0,
    PRE_DIV8   = 1'b1
  } pre_sel_e;

  localparam int DEF_CD_W   = 16;
  localparam int DEF_BD_W   = 8;
  localparam int DEF_BD_MIN = 4;
  localparam int DEF_PRE    = 8;

endpackage

// File: rtl/bg_cfg.sv
module bg_cfg
  import bitrate_pkg::*;
#(
  parameter int CD_W   = DEF_CD_W,
  parameter int BD_W   = DEF_BD_W,
  parameter int BD_MIN = DEF_BD_MIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [CD_W-1:0] wr_cd,
  input  logic [BD_W-1:0] wr_bd,
  input  pre_sel_e        wr_pre,
  input  logic            apply,
  output logic [CD_W-1:0] act_cd,
  output logic [BD_W-1:0] act_bd,
  output pre_sel_e        act_pre
);

  logic [CD_W-1:0] pend_cd;
  logic [BD_W-1:0] pend_bd;
  pre_sel_e        pend_pre;
  logic            load;

  // a stopped generator has no wrap to wait for
  assign load = apply || (act_cd == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cd  <= '0;
      pend_bd  <= BD_W'(BD_MIN);
      pend_pre <= PRE_BYPASS;
    end else if (wr) begin
      pend_cd  <= wr_cd;
      pend_bd  <= wr_bd;
      pend_pre <= wr_pre;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cd  <= '0;
      act_bd  <= BD_W'(BD_MIN);
      act_pre <= PRE_BYPASS;
    end else if (load) begin
      act_cd  <= pend_cd;
      act_bd  <= pend_bd;
      act_pre <= pend_pre;
    end
  end

  // R8: a running setting changes only at a wrap
  p_hold_until_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (!apply && act_cd != '0) |=> ($stable(act_cd) && $stable(act_bd) && $stable(act_pre)));

endmodule

// File: rtl/bg_prescale.sv
module bg_prescale
  import bitrate_pkg::*;
#(
  parameter int DIV = DEF_PRE
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  pre_sel_e sel,
  input  logic     restart,
  output logic     en
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt;

  assign en = run && ((sel == PRE_DIV8) ? (cnt == LAST) : 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt <= '0;
    end else if (sel == PRE_DIV8) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

endmodule

// File: rtl/bg_clkdiv.sv
module bg_clkdiv #(
  parameter int CD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [CD_W-1:0] div,
  output logic            wrap,
  output logic            stb
);

  logic [CD_W-1:0] cnt;

  assign wrap = en && (div != '0) && (cnt == div - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || div == '0) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stb <= 1'b0;
    else     stb <= wrap;
  end

  // R2: the count never passes the running divisor
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    (div != '0) |-> (cnt < div));

  // R6: a zero divisor produces no strobe
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !stb);

endmodule

// File: rtl/bg_bitdiv.sv
module bg_bitdiv #(
  parameter int BD_W   = 8,
  parameter int BD_MIN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            step,
  input  logic [BD_W-1:0] bd_raw,
  output logic            tick
);

  logic [BD_W-1:0] eff;
  logic [BD_W-1:0] scnt;
  logic            last;

  // R5: clamp the bit divisor at its minimum
  assign eff  = (bd_raw < BD_W'(BD_MIN)) ? BD_W'(BD_MIN) : bd_raw;
  assign last = (scnt >= eff);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      scnt <= '0;
    end else if (step) begin
      scnt <= last ? '0 : scnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= step && last;
  end

  // R5: a bit never holds fewer than BD_MIN+1 samples
  p_min_samples_r5: assert property (@(posedge clk) disable iff (rst)
    (step && last) |-> (scnt >= BD_W'(BD_MIN)));

endmodule

// File: rtl/bitrate_gen.sv
module bitrate_gen
  import bitrate_pkg::*;
#(
  parameter int CD_W   = DEF_CD_W,
  parameter int BD_W   = DEF_BD_W,
  parameter int BD_MIN = DEF_BD_MIN,
  parameter int PRE    = DEF_PRE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [CD_W-1:0] cfg_clk_div,
  input  logic [BD_W-1:0] cfg_bit_div,
  input  logic            cfg_pre_sel,
  output logic            sample_stb,
  output logic            bit_tick
);

  logic [CD_W-1:0] act_cd;
  logic [BD_W-1:0] act_bd;
  pre_sel_e        act_pre;
  pre_sel_e        wr_pre;
  logic            run;
  logic            pre_en;
  logic            wrap;

  assign wr_pre = cfg_pre_sel ? PRE_DIV8 : PRE_BYPASS;
  assign run    = (act_cd != '0);

  bg_cfg #(.CD_W(CD_W), .BD_W(BD_W), .BD_MIN(BD_MIN)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr     (cfg_wr),
    .wr_cd  (cfg_clk_div),
    .wr_bd  (cfg_bit_div),
    .wr_pre (wr_pre),
    .apply  (wrap),
    .act_cd (act_cd),
    .act_bd (act_bd),
    .act_pre(act_pre)
  );

  bg_prescale #(.DIV(PRE)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .sel    (act_pre),
    .restart(wrap),
    .en     (pre_en)
  );

  bg_clkdiv #(.CD_W(CD_W)) u_cd (
    .clk (clk),
    .rst (rst),
    .en  (pre_en),
    .div (act_cd),
    .wrap(wrap),
    .stb (sample_stb)
  );

  bg_bitdiv #(.BD_W(BD_W), .BD_MIN(BD_MIN)) u_bd (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .step  (wrap),
    .bd_raw(act_bd),
    .tick  (bit_tick)
  );

  // R4: a bit tick always rides on a sample strobe
  p_tick_on_stb_r4: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_stb);

  // R3: with the prescaler in use, strobes are never back to back
  p_pre_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && act_pre == PRE_DIV8) |=> !sample_stb);

endmodule

// File: tb/tb_bitrate_gen.sv
module tb_bitrate_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_clk_div = '0;
  logic [7:0]  cfg_bit_div = '0;
  logic        cfg_pre_sel = 1'b0;
  logic        sample_stb;
  logic        bit_tick;

  int checks = 0;
  int fails  = 0;
  int stray_ticks = 0;

  always #10 clk = ~clk;  // 50 MHz

  bitrate_gen dut (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_clk_div(cfg_clk_div),
    .cfg_bit_div(cfg_bit_div),
    .cfg_pre_sel(cfg_pre_sel),
    .sample_stb (sample_stb),
    .bit_tick   (bit_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // call just after a negedge; returns just after the next one
  task automatic cfg_write(input int cd, input int bd, input bit pre);
    cfg_clk_div = 16'(cd);
    cfg_bit_div = 8'(bd);
    cfg_pre_sel = pre;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic next_stb(output int gap, output bit tk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      if (bit_tick && !sample_stb) stray_ticks++;
    end while (!sample_stb && gap < 5000);
    tk = bit_tick;
  endtask

  // R2/R3/R4/R5/R7 for one setting started from a stopped state
  task automatic run_rate(input string tag, input int cd, input int bd, input bit pre);
    int p, eff, gap, bad_gap, bad_tick;
    bit tk;
    p   = pre ? 8 : 1;
    eff = (bd < 4) ? 4 : bd;
    bad_gap = 0; bad_tick = 0; stray_ticks = 0;
    do_reset();
    cfg_write(cd, bd, pre);
    next_stb(gap, tk);
    chk({tag, " R7 first strobe latency"}, gap, p * cd + 1);
    if (tk != (1 % (eff + 1) == 0)) bad_tick++;
    for (int n = 2; n <= 3 * (eff + 1); n++) begin
      next_stb(gap, tk);
      if (gap != p * cd) bad_gap++;
      if (tk != (n % (eff + 1) == 0)) bad_tick++;
    end
    chk({tag, " strobe period mismatches (R2/R3)"}, bad_gap, 0);
    chk({tag, " R4 tick placement mismatches"}, bad_tick + stray_ticks, 0);
  endtask

  task automatic test_reset_state();
    int seen;
    do_reset();
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (sample_stb || bit_tick) seen++;
    end
    chk("R1 outputs quiet after reset", seen, 0);
  endtask

  task automatic test_zero_cd();
    int seen;
    do_reset();
    cfg_write(0, 9, 0);
    seen = 0;
    repeat (200) begin
      @(negedge clk);
      if (sample_stb || bit_tick) seen++;
    end
    chk("R6 zero clock divisor stops output", seen, 0);
  endtask

  task automatic test_live_update();
    int gap;
    bit tk;
    do_reset();
    cfg_write(4, 4, 0);
    next_stb(gap, tk);
    cfg_write(2, 4, 0);
    next_stb(gap, tk);
    chk("R8 period in progress keeps old length", gap + 1, 4);
    next_stb(gap, tk);
    chk("R8 new divisor used after wrap", gap, 2);
    cfg_write(2, 4, 1);
    next_stb(gap, tk);
    chk("R8 prescale switch waits for wrap", gap + 1, 2);
    next_stb(gap, tk);
    chk("R8 R3 prescaled period after switch", gap, 16);
  endtask

  task automatic test_reset_midrun();
    int seen, gap;
    bit tk;
    do_reset();
    cfg_write(2, 4, 0);
    next_stb(gap, tk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (sample_stb || bit_tick) seen++;
    end
    chk("R1 reset during run clears and stops", seen, 0);
  endtask

  initial begin
    test_reset_state();
    run_rate("cd3 bd4", 3, 4, 1'b0);
    run_rate("cd1 bd7", 1, 7, 1'b0);
    run_rate("cd2 bd5 pre8", 2, 5, 1'b1);
    run_rate("R5 clamp bd1", 3, 1, 1'b0);
    run_rate("R5 clamp bd0", 2, 0, 1'b0);
    test_zero_cd();
    test_live_update();
    test_reset_midrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule